// File: doc/BRIEF.md
# Cascadable Eight-Function ALU Word

This block is a purely combinational arithmetic logic unit built from four-bit slices. Each slice takes two four-bit operands, a three-bit function code and a carry input. It returns a four-bit result, a carry output and a two's-complement overflow flag. The function codes cover three arithmetic operations, three bitwise logic operations, and two forced results (all zeros and all ones).

The top level chains a parameterised number of slices. The carry output of each slice drives the carry input of the next more significant slice. The word-level carry and overflow come from the most significant slice. With the default of four slices the word is 16 bits wide.

For subtraction the caller drives the word carry input high to get a true two's-complement difference. A high carry output after a subtraction means that no borrow occurred. No clock or reset enters the block.

Top module: `alu_ripple_word`

## Requirements
- R1: Function code 3'b000 forces every result bit to 0, with carry_out and overflow both 0.
- R2: Function code 3'b111 forces every result bit to 1, with carry_out and overflow both 0.
- R3: Function code 3'b011 gives {carry_out, result} = op_a + op_b + carry_in over the full word width.
- R4: Function code 3'b010 gives {carry_out, result} = op_a + ~op_b + carry_in. With carry_in = 1 the result is op_a - op_b modulo 2^W, and carry_out is 1 exactly when op_a >= op_b, taken as unsigned values.
- R5: Function code 3'b001 gives {carry_out, result} = op_b + ~op_a + carry_in. With carry_in = 1 the result is op_b - op_a, and carry_out is 1 exactly when op_b >= op_a.
- R6: Function codes 3'b100, 3'b101 and 3'b110 give the bitwise XOR, OR and AND of the operands, with carry_out and overflow both 0.
- R7: In the three arithmetic codes, overflow is 1 exactly when the two addends have equal sign bits and the sign bit of the result differs from them. This equals the carry into the top bit XOR the carry out of it.
- R8: Carries ripple from slice to slice. The word carry_out equals the carry out of the full-width operation and does not stop at a slice boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4*SLICES | First operand |
| op_b | input | 4*SLICES | Second operand |
| func_sel | input | 3 | Function code |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | 4*SLICES | Function result |
| carry_out | output | 1 | Carry out of the most significant slice |
| overflow | output | 1 | Two's-complement overflow of the most significant slice |

## Verification
The embedded checks are immediate assertions on settled combinational values. They take for granted that every input has a defined level. They also take for granted that the carry-into-the-word conventions of R4 and R5 apply only when carry_in is high; the no-borrow checks are gated on that condition. The bench drives every input from a registered process at a rising edge and compares half a period later, so the assertions and the comparison only ever see settled values. The operands come from a corner set (zero, one, the sign boundaries, all ones, nibble-crossing patterns) combined exhaustively with every code and both carry levels, followed by a long pseudo-random sweep.

// File: rtl/alu_word_pkg.sv
// Package: function codes and shared constants for the ALU word.
// Assumes: codes are decoded exactly as listed; the code values are behaviour.
package alu_word_pkg;

    localparam int SLICE_W = 4;

    typedef enum logic [2:0] {
        FN_ZERO    = 3'b000,
        FN_B_SUB_A = 3'b001,
        FN_A_SUB_B = 3'b010,
        FN_ADD     = 3'b011,
        FN_XOR     = 3'b100,
        FN_OR      = 3'b101,
        FN_AND     = 3'b110,
        FN_ONES    = 3'b111
    } fn_code_t;

    // True for the three codes that use the adder.
    function automatic logic fn_is_arith(input logic [2:0] code);
        return (code == FN_B_SUB_A) || (code == FN_A_SUB_B) || (code == FN_ADD);
    endfunction

endpackage

// File: rtl/alu_arith_unit.sv
// Module: conditioned ripple adder for one slice.
// Does: selects and inverts the addends for add, A-B and B-A, and ripples the carry bit by bit.
// Assumes: the caller gates its flags outside the arithmetic codes.
module alu_arith_unit
    import alu_word_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       code,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] addend_x;
    logic [WIDTH-1:0] addend_y;
    logic             carry_into_top;

    // Pick the two addends: B-A adds B to ~A, A-B adds A to ~B.
    always_comb begin
        addend_x = (code == FN_B_SUB_A) ? opnd_b : opnd_a;
        if (code == FN_B_SUB_A)
            addend_y = ~opnd_a;
        else if (code == FN_A_SUB_B)
            addend_y = ~opnd_b;
        else
            addend_y = opnd_b;
    end

    // Ripple the carry through each bit, keeping the carry into the top bit.
    always_comb begin
        logic cr;
        cr             = cin;
        carry_into_top = 1'b0;
        sum            = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (i == TOP)
                carry_into_top = cr;
            sum[i] = addend_x[i] ^ addend_y[i] ^ cr;
            cr     = (addend_x[i] & addend_y[i]) | ((addend_x[i] ^ addend_y[i]) & cr);
        end
        cout = cr;
    end

    // Overflow is the disagreement of the carries into and out of the top bit.
    always_comb begin
        ovf = carry_into_top ^ cout;
    end

    // Check that overflow agrees with the sign rule on the conditioned addends.
    always_comb begin : chk_arith
        AST_OVF_SIGN_RULE: assert (ovf == ((addend_x[TOP] == addend_y[TOP]) && (sum[TOP] != addend_x[TOP])))
            else $error("overflow disagrees with sign rule"); // R7
    end

endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise and forced-value results for one slice.
// Does: XOR, OR, AND, all-zero and all-one outputs; the arithmetic codes give zero here.
// Assumes: the slice mux selects the adder for the arithmetic codes.
module alu_logic_unit
    import alu_word_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       code,
    output logic [WIDTH-1:0] res
);

    // Decode the non-arithmetic codes into a result.
    always_comb begin
        case (code)
            FN_XOR:  res = opnd_a ^ opnd_b;
            FN_OR:   res = opnd_a | opnd_b;
            FN_AND:  res = opnd_a & opnd_b;
            FN_ONES: res = '1;
            default: res = '0;
        endcase
    end

    // Check the set relations of the OR and AND results against the operands.
    always_comb begin : chk_logic
        AST_AND_WITHIN_A: assert (!(code == FN_AND) || ((res & ~opnd_a) == '0))
            else $error("AND result outside A"); // R6
        AST_OR_COVERS_B: assert (!(code == FN_OR) || ((res & opnd_b) == opnd_b))
            else $error("OR result misses B"); // R6
    end

endmodule

// File: rtl/alu_slice.sv
// Module: one four-bit ALU slice.
// Does: runs the adder and the logic unit in parallel and selects between them by code.
// Assumes: carry and overflow are meaningful only for the arithmetic codes and are held low otherwise.
module alu_slice
    import alu_word_pkg::*;
#(
    parameter int WIDTH = SLICE_W
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       code,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ovf
);

    logic [WIDTH-1:0] arith_sum;
    logic             arith_cout;
    logic             arith_ovf;
    logic [WIDTH-1:0] logic_res;
    logic             use_adder;

    alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .code   (code),
        .cin    (cin),
        .sum    (arith_sum),
        .cout   (arith_cout),
        .ovf    (arith_ovf)
    );

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .code   (code),
        .res    (logic_res)
    );

    // Choose the adder or the logic path and gate the flags.
    always_comb begin
        use_adder = fn_is_arith(code);
        res       = use_adder ? arith_sum : logic_res;
        cout      = use_adder & arith_cout;
        ovf       = use_adder & arith_ovf;
    end

    // Check the forced codes, the quiet flags and the no-borrow rule.
    always_comb begin : chk_slice
        AST_CLEAR_LOW: assert (!(code == FN_ZERO) || (res == '0))
            else $error("clear not low"); // R1
        AST_PRESET_HIGH: assert (!(code == FN_ONES) || (&res))
            else $error("preset not high"); // R2
        AST_FLAGS_QUIET: assert (fn_is_arith(code) || (!cout && !ovf))
            else $error("flags active outside arithmetic"); // R6
        AST_A_SUB_NO_BORROW: assert (!(code == FN_A_SUB_B && cin) || (cout == (opnd_a >= opnd_b)))
            else $error("A-B borrow wrong"); // R4
        AST_B_SUB_NO_BORROW: assert (!(code == FN_B_SUB_A && cin) || (cout == (opnd_b >= opnd_a)))
            else $error("B-A borrow wrong"); // R5
    end

endmodule

// File: rtl/alu_ripple_word.sv
// Module: word-wide ALU built from a ripple chain of slices.
// Does: splits the operands into nibbles, chains the slice carries, and reports the top slice's flags.
// Assumes: carry_in is held high by the caller for a true subtraction.
module alu_ripple_word
    import alu_word_pkg::*;
#(
    parameter int SLICES = 4
) (
    input  logic [SLICE_W*SLICES-1:0] op_a,
    input  logic [SLICE_W*SLICES-1:0] op_b,
    input  logic [2:0]                func_sel,
    input  logic                      carry_in,
    output logic [SLICE_W*SLICES-1:0] result,
    output logic                      carry_out,
    output logic                      overflow
);

    localparam int WORD_W = SLICE_W * SLICES;

    logic [SLICES:0]   link;
    logic [SLICES-1:0] slice_ovf;

    assign link[0] = carry_in;

    // One slice per nibble, each fed by the carry of the slice below.
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        alu_slice #(.WIDTH(SLICE_W)) u_slice (
            .opnd_a (op_a[s*SLICE_W +: SLICE_W]),
            .opnd_b (op_b[s*SLICE_W +: SLICE_W]),
            .code   (func_sel),
            .cin    (link[s]),
            .res    (result[s*SLICE_W +: SLICE_W]),
            .cout   (link[s+1]),
            .ovf    (slice_ovf[s])
        );
    end

    // Word flags come from the most significant slice.
    always_comb begin
        carry_out = link[SLICES];
        overflow  = slice_ovf[SLICES-1];
    end

    // Check the whole chain against a single full-width sum.
    always_comb begin : chk_word
        AST_WORD_ADD: assert (!(func_sel == FN_ADD) ||
                              ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b} + {{WORD_W{1'b0}}, carry_in})))
            else $error("word add mismatch"); // R8
    end

endmodule

// File: tb/alu_ripple_word_bench.sv
// Bench: a scoreboard for the ALU word. The driver pushes expected items into a queue,
// and the monitor pops and compares them half a clock later.
module alu_ripple_word_bench;

    localparam int SL = 4;
    localparam int W  = 4 * SL;

    typedef struct {
        logic [W-1:0] res;
        logic         co;
        logic         ov;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [2:0]   func_sel = 3'b000;
    logic         carry_in = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         overflow;

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    exp_t  sbq[$];
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    alu_ripple_word #(.SLICES(SL)) u_alu_ripple_word (
        .op_a      (op_a),
        .op_b      (op_b),
        .func_sel  (func_sel),
        .carry_in  (carry_in),
        .result    (result),
        .carry_out (carry_out),
        .overflow  (overflow)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [2:0] s, input logic [W-1:0] a,
                                   input logic [W-1:0] b, input logic c);
        exp_t e;
        logic [W:0]   t;
        logic [W-1:0] x;
        logic [W-1:0] y;
        e.res = '0; e.co = 1'b0; e.ov = 1'b0;
        x = a; y = b;
        case (s)
            3'b000: begin e.res = '0; e.tag = "R1"; end
            3'b111: begin e.res = '1; e.tag = "R2"; end
            3'b100: begin e.res = a ^ b; e.tag = "R6"; end
            3'b101: begin e.res = a | b; e.tag = "R6"; end
            3'b110: begin e.res = a & b; e.tag = "R6"; end
            default: begin
                if (s == 3'b001) begin x = b; y = ~a; e.tag = "R5"; end
                else if (s == 3'b010) begin x = a; y = ~b; e.tag = "R4"; end
                else e.tag = "R3";
                t = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
                e.res = t[W-1:0];
                e.co  = t[W];
                e.ov  = (x[W-1] == y[W-1]) && (e.res[W-1] != x[W-1]);
            end
        endcase
        return e;
    endfunction

    // Driver: apply one vector at a rising edge and queue its expectation.
    task automatic drive(input logic [2:0] s, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic c);
        @(posedge clk);
        func_sel = s; op_a = a; op_b = b; carry_in = c;
        sbq.push_back(model(s, a, b, c));
    endtask

    // One step of a xorshift generator.
    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    // Monitor: compare settled outputs half a period after each drive.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            total++;
            if (result !== e.res) begin
                bad++;
                $display("FAIL %s result code=%b a=%h b=%h cin=%b got=%h exp=%h",
                         e.tag, func_sel, op_a, op_b, carry_in, result, e.res);
            end
            total++;
            if (carry_out !== e.co) begin
                bad++;
                $display("FAIL R8 carry code=%b a=%h b=%h cin=%b got=%b exp=%b",
                         func_sel, op_a, op_b, carry_in, carry_out, e.co);
            end
            total++;
            if (overflow !== e.ov) begin
                bad++;
                $display("FAIL R7 overflow code=%b a=%h b=%h cin=%b got=%b exp=%b",
                         func_sel, op_a, op_b, carry_in, overflow, e.ov);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Stimulus: reset state, corner set, then a random sweep.
    initial begin
        logic [W-1:0] corners [8];
        corners[0] = 16'h0000; corners[1] = 16'h0001; corners[2] = 16'h7FFF; corners[3] = 16'h8000;
        corners[4] = 16'hFFFF; corners[5] = 16'h00FF; corners[6] = 16'h0F0F; corners[7] = 16'h5555;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset-time state: clear code with zero operands (R1).
        drive(3'b000, '0, '0, 1'b0);
        // Ripple across every slice boundary (R8, R3).
        drive(3'b011, 16'hFFFF, 16'h0000, 1'b1);
        drive(3'b011, 16'h0FFF, 16'h0001, 1'b0);
        // Subtractions with and without borrow (R4, R5).
        drive(3'b010, 16'h1000, 16'h0001, 1'b1);
        drive(3'b010, 16'h0001, 16'h1000, 1'b1);
        drive(3'b001, 16'h0003, 16'h0003, 1'b1);
        // Signed overflow at the sign boundary (R7).
        drive(3'b011, 16'h7FFF, 16'h0001, 1'b0);
        drive(3'b010, 16'h8000, 16'h0001, 1'b1);
        // Corner set against every code and carry level (R1..R8).
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < 8; i++)
                    for (int j = 0; j < 8; j++)
                        drive(3'(s), corners[i], corners[j], 1'(c));
        // Random sweep over every code and carry level (R1..R8).
        for (int s = 0; s < 8; s++)
            for (int c = 0; c < 2; c++)
                for (int n = 0; n < 1500; n++) begin
                    logic [W-1:0] ra;
                    step_rng();
                    ra = rng[W-1:0];
                    step_rng();
                    drive(3'(s), ra, rng[W-1:0], 1'(c));
                end
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule